// File: doc/BRIEF.md
# Serial Transmit FIFO Channel

A transmit channel for one half-duplex serial line. A controller writes bytes through a strobe, and each byte can be bit-reversed on entry. The bytes queue in a four-entry circular FIFO, and a shift register sends them out on a single data pin. A go command arms a transmission: either the channel's own go input or a global go input shared by several channels. The go first waits a programmable wire-delay count and then shifts bits at a rate set by an integer divider of the system clock. While bits are on the wire, an output-enable pin drives the line transceiver. A debug clock pin shows the bit timing.

A frame ends in one of two ways. With a frame size of zero, the frame ends when the FIFO is empty at a byte boundary. With a nonzero frame size, the frame lasts exactly that many bits and is padded with ones when the FIFO is empty. The divider value is taken at every bit boundary. Software can therefore retune the rate between bits, for example to place an edge at one-eighth-bit resolution, without ever producing a partial bit. Bytes written after a frame has ended wait in the FIFO for the next go.

Top module: `ser_tx_channel`

## Requirements
- R1: After reset: `ser_o`=1, `oe_o`=0, `bclk_o`=1, `busy_o`=0, `level_o`=0, `overrun_o`=0, `underrun_o`=0.
- R2: With `swap_i`=0 a byte is sent bit 7 first. With `swap_i`=1 at write time the byte is stored bit-reversed, so bit 0 goes out first.
- R3: `level_o` counts stored bytes (0..4). `fill_code_o` is 0 for empty, 1 for 1 or 2 bytes, 2 for 3 bytes and 3 for 4 bytes.
- R4: A write when 4 bytes are stored and no byte leaves in that cycle is discarded. It sets `overrun_o`, which stays set until reinit.
- R5: If the delay expires with an empty FIFO and `frame_bits_i`=0, `underrun_o` is set (sticky until reinit) and no bit is sent. With a nonzero frame size, underrun never occurs.
- R6: If `go_i` or `global_go_i` is sampled high while idle, with delay D, the first bit appears D+1 cycles after the sampling edge. `busy_o` is high from that edge onward. Either go input is ignored while busy.
- R7: Each bit lasts `div_i` cycles (0 counts as 1). The divider is captured when shifting starts and at each bit boundary, so a change in mid-bit acts from the next bit on.
- R8: With frame size 0, a byte written before the current byte's last bit ends follows without a gap. An empty FIFO at a byte boundary ends the frame. Bytes written later stay queued until a new go.
- R9: With frame size F>0, exactly F bits are sent. They are padded with ones when the FIFO is empty, and a partly sent byte is cut off at F.
- R10: `oe_o` is high exactly while bits are shifted. `busy_o` falls at the end of the last bit. `ser_o` is 1 whenever `oe_o` is low.
- R11: `reinit_i` clears the pointers, level and flags and aborts a transfer. While it is high, `oe_o`=0, `bclk_o`=1 and go inputs have no effect.
- R12: During a bit of length D, `bclk_o` is low for the first floor(D/2) cycles and high for the rest. When not shifting, it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| reinit_i | input | 1 | clear FIFO and flags, abort transfer |
| wr_i | input | 1 | write strobe |
| wr_data_i | input | 8 | byte to queue |
| swap_i | input | 1 | reverse bit order of written byte |
| go_i | input | 1 | channel go |
| global_go_i | input | 1 | shared go |
| div_i | input | 8 | system cycles per bit |
| frame_bits_i | input | 8 | frame length in bits, 0 = until FIFO empty |
| wire_delay_i | input | 8 | cycles waited after go before first bit |
| ser_o | output | 1 | serial data |
| oe_o | output | 1 | transceiver output enable |
| bclk_o | output | 1 | debug bit clock |
| level_o | output | 3 | stored byte count |
| fill_code_o | output | 2 | fill status code |
| overrun_o | output | 1 | sticky overrun flag |
| underrun_o | output | 1 | sticky underrun flag |
| busy_o | output | 1 | transfer in progress |

## Verification
The bound checker watches the properties that hold on every cycle. It checks the idle-high line and the debug clock whenever enable is low, that enable is never high without busy, that the level stays within bounds, that overrun stays set, that underrun rises only with a zero frame size, and the state one cycle after reinit. Other behaviour depends on a whole transfer and only the bench scenarios can show it. This covers the exact bit order with and without swap, the delay-to-first-bit timing, bit lengths across a divider change in mid-bit, padding and truncation to the frame size, and bytes that are back-to-back or left queued. The bench compares each of these cycle by cycle against a waveform it builds itself.

// File: rtl/tx_chan_pkg.sv
package tx_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;

  // 0 empty, 1 near-empty, 2 near-full, 3 full
  function automatic logic [1:0] fill_code(input int unsigned cnt, input int unsigned depth);
    if (cnt == 0)              return 2'd0;
    else if (cnt >= depth)     return 2'd3;
    else if (cnt == depth - 1) return 2'd2;
    else                       return 2'd1;
  endfunction

endpackage

// File: rtl/tx_bit_rev.sv
module tx_bit_rev #(
  parameter int DW = 8
) (
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] d_o
);
  logic [DW-1:0] rev;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign rev[i] = d_i[DW-1-i];
  end

  assign d_o = en_i ? rev : d_i;
endmodule

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          overrun_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovr_q;
  logic          full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && !do_push) ovr_q <= 1'b1;
    end
  end

  assign dout_o    = mem_q[rd_ptr_q];
  assign count_o   = cnt_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/tx_baud.sv
module tx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o,
  output logic             bclk_o
);
  logic [DIV_W-1:0] cnt_q, div_act_q, div_eff;

  assign div_eff   = (div_i == '0) ? DIV_W'(1) : div_i;
  assign bit_end_o = run_i && (cnt_q == div_act_q - 1'b1);
  assign bclk_o    = !run_i || (cnt_q >= (div_act_q >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      div_act_q <= DIV_W'(1);
    end else if (start_i || bit_end_o) begin
      // divider only changes on a bit boundary
      cnt_q     <= '0;
      div_act_q <= div_eff;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ser_tx_channel.sv
module ser_tx_channel
  import tx_chan_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 4,
  parameter int DIV_W   = 8,
  parameter int FRAME_W = 8,
  parameter int DLY_W   = 8,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int IDX_W  = $clog2(DW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reinit_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               swap_i,
  input  logic               go_i,
  input  logic               global_go_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic [DLY_W-1:0]   wire_delay_i,
  output logic               ser_o,
  output logic               oe_o,
  output logic               bclk_o,
  output logic [CW-1:0]      level_o,
  output logic [1:0]         fill_code_o,
  output logic               overrun_o,
  output logic               underrun_o,
  output logic               busy_o
);
  tx_state_e          state_q, state_d;
  logic [DLY_W-1:0]   dly_q, dly_d;
  logic [DW-1:0]      sr_q, sr_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] sent_q, sent_d;
  logic               unr_q, unr_d;
  logic               pop, start, bit_end, baud_clk;
  logic [DW-1:0]      wr_byte, head;
  logic [CW-1:0]      cnt;
  logic               fifo_empty, frame_fixed, go_any;

  tx_bit_rev #(.DW(DW)) i_rev (
    .en_i (swap_i),
    .d_i  (wr_data_i),
    .d_o  (wr_byte)
  );

  tx_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (reinit_i),
    .push_i    (wr_i),
    .din_i     (wr_byte),
    .pop_i     (pop),
    .dout_o    (head),
    .count_o   (cnt),
    .overrun_o (overrun_o)
  );

  tx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .run_i     (state_q == ST_SHIFT),
    .div_i     (div_i),
    .bit_end_o (bit_end),
    .bclk_o    (baud_clk)
  );

  assign fifo_empty  = (cnt == '0);
  assign frame_fixed = (frame_bits_i != '0);
  assign go_any      = go_i || global_go_i;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    sr_d    = sr_q;
    idx_d   = idx_q;
    sent_d  = sent_q;
    unr_d   = unr_q;
    pop     = 1'b0;
    start   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_any) begin
          state_d = ST_WAIT;
          dly_d   = wire_delay_i;
        end
      end
      ST_WAIT: begin
        if (dly_q != '0) begin
          dly_d = dly_q - 1'b1;
        end else if (fifo_empty && !frame_fixed) begin
          unr_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_SHIFT;
          start   = 1'b1;
          pop     = !fifo_empty;
          sr_d    = fifo_empty ? '1 : head;
          idx_d   = '0;
          sent_d  = '0;
        end
      end
      ST_SHIFT: begin
        if (bit_end) begin
          sent_d = sent_q + 1'b1;
          if (frame_fixed && (sent_q == frame_bits_i - 1'b1)) begin
            state_d = ST_IDLE;
          end else if (idx_q == IDX_W'(DW - 1)) begin
            idx_d = '0;
            if (!fifo_empty) begin
              pop  = 1'b1;
              sr_d = head;
            end else if (frame_fixed) begin
              sr_d = '1;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            idx_d = idx_q + 1'b1;
            sr_d  = {sr_q[DW-2:0], 1'b1};
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
      sr_q    <= '1;
      idx_q   <= '0;
      sent_q  <= '0;
      unr_q   <= 1'b0;
    end else if (reinit_i) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
      sr_q    <= '1;
      idx_q   <= '0;
      sent_q  <= '0;
      unr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      sr_q    <= sr_d;
      idx_q   <= idx_d;
      sent_q  <= sent_d;
      unr_q   <= unr_d;
    end
  end

  assign oe_o        = (state_q == ST_SHIFT);
  assign ser_o       = oe_o ? sr_q[DW-1] : 1'b1;
  assign bclk_o      = baud_clk;
  assign busy_o      = (state_q != ST_IDLE);
  assign underrun_o  = unr_q;
  assign level_o     = cnt;
  assign fill_code_o = fill_code(int'(cnt), DEPTH);
endmodule

// File: rtl/tx_chan_checker.sv
module tx_chan_checker #(
  parameter int DEPTH   = 4,
  parameter int FRAME_W = 8,
  parameter int CW      = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reinit_i,
  input logic               ser_o,
  input logic               oe_o,
  input logic               bclk_o,
  input logic               busy_o,
  input logic [CW-1:0]      level_o,
  input logic               overrun_o,
  input logic               underrun_o,
  input logic [FRAME_W-1:0] frame_bits_i
);
  assert_reinit_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (level_o == '0 && !oe_o && bclk_o && !busy_o && !overrun_o && !underrun_o));

  assert_line_idle_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> ser_o);

  assert_oe_within_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> busy_o);

  assert_bclk_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> bclk_o);

  assert_level_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));

  assert_overrun_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !reinit_i) |=> overrun_o);

  assert_underrun_zero_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> ($past(frame_bits_i) == '0));
endmodule

bind ser_tx_channel tx_chan_checker #(
  .DEPTH   (DEPTH),
  .FRAME_W (FRAME_W),
  .CW      (CW)
) i_tx_chan_checker (.*);

// File: tb/test_ser_tx_channel.sv
module test_ser_tx_channel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reinit_i = 1'b0, wr_i = 1'b0, swap_i = 1'b0, go_i = 1'b0, global_go_i = 1'b0;
  logic [7:0] wr_data_i = '0, div_i = 8'd1, frame_bits_i = '0, wire_delay_i = '0;
  logic       ser_o, oe_o, bclk_o, overrun_o, underrun_o, busy_o;
  logic [2:0] level_o;
  logic [1:0] fill_code_o;

  int total = 0, bad = 0;
  logic [7:0] tb_bytes [4];
  bit exp_bit [64];
  int exp_dur [64];
  int exp_n, exp_delay;
  int ev_go_j, ev_wr_j, chg_j;
  logic [7:0] ev_wr_b, chg_div;

  always #4 clk_i = ~clk_i;

  ser_tx_channel i_ser_tx_channel (.*);

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  function automatic int code_of(input int n);
    if (n == 0) return 0;
    if (n >= 4) return 3;
    if (n == 3) return 2;
    return 1;
  endfunction

  task automatic clr_events();
    ev_go_j = -10; ev_wr_j = -10; chg_j = -10;
  endtask

  task automatic pulse_reinit();
    @(negedge clk_i); reinit_i = 1'b1;
    @(negedge clk_i); reinit_i = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk_i); wr_i = 1'b1; wr_data_i = b;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic build(input int nb, input int frm, input bit sw, input int dv);
    logic [7:0] b;
    exp_n = (frm == 0) ? 8 * nb : frm;
    for (int k = 0; k < exp_n; k++) begin
      if (k / 8 < nb) begin
        b = sw ? rev8(tb_bytes[k/8]) : tb_bytes[k/8];
        exp_bit[k] = b[7 - (k % 8)];
      end else begin
        exp_bit[k] = 1'b1;
      end
      exp_dur[k] = (dv == 0) ? 1 : dv;
    end
  endtask

  task automatic setup(input int nb, input int frm, input bit sw, input int dv, input int dly);
    pulse_reinit();
    swap_i = sw; div_i = 8'(dv); frame_bits_i = 8'(frm); wire_delay_i = 8'(dly);
    exp_delay = dly;
    for (int i = 0; i < nb; i++) write_byte(tb_bytes[i]);
    build(nb, frm, sw, dv);
  endtask

  // drive a go, then compare {busy,oe,ser,bclk} each cycle against the built waveform
  task automatic run_check(input bit glob, input string req);
    int tsum, kk, off, nerr, fj;
    logic [3:0] a, e, fa, fe;
    tsum = 0;
    for (int k = 0; k < exp_n; k++) tsum += exp_dur[k];
    kk = 0; off = 0; nerr = 0; fj = 0; fa = '0; fe = '0;
    @(negedge clk_i);
    if (glob) global_go_i = 1'b1; else go_i = 1'b1;
    for (int j = 0; j < exp_delay + 1 + tsum + 2; j++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (j == 0) begin go_i = 1'b0; global_go_i = 1'b0; end
      if (j <= exp_delay) e = 4'b1011;
      else if (kk < exp_n) begin
        e = {1'b1, 1'b1, exp_bit[kk], (off >= exp_dur[kk] / 2)};
        off++;
        if (off == exp_dur[kk]) begin kk++; off = 0; end
      end else e = 4'b0011;
      a = {busy_o, oe_o, ser_o, bclk_o};
      if (a !== e) begin
        if (nerr == 0) begin fj = j; fa = a; fe = e; end
        nerr++;
      end
      if (j == ev_go_j) go_i = 1'b1;
      else if (j == ev_go_j + 1) go_i = 1'b0;
      if (j == ev_wr_j) begin wr_i = 1'b1; wr_data_i = ev_wr_b; end
      else if (j == ev_wr_j + 1) wr_i = 1'b0;
      if (j == chg_j) div_i = chg_div;
    end
    check(nerr == 0, req, $sformatf("waveform {busy,oe,ser,bclk} at sample %0d", fj), int'(fa), int'(fe));
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nb, frm, dv, dly, rem, ld;
    bit sw, gl;
    void'($urandom(32'd20240611));
    clr_events();
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check({ser_o, oe_o, bclk_o, busy_o} == 4'b1010, "R1", "ser/oe/bclk/busy", int'({ser_o, oe_o, bclk_o, busy_o}), 10);
    check(level_o == 0 && !overrun_o && !underrun_o, "R1", "level/flags", int'({level_o, overrun_o, underrun_o}), 0);

    // R3 fill status, R4 overrun
    tb_bytes[0] = 8'h11; tb_bytes[1] = 8'h22; tb_bytes[2] = 8'h33; tb_bytes[3] = 8'h44;
    for (int i = 0; i < 4; i++) begin
      write_byte(tb_bytes[i]);
      check(level_o == 3'(i + 1), "R3", "level", int'(level_o), i + 1);
      check(fill_code_o == 2'(code_of(i + 1)), "R3", "fill code", int'(fill_code_o), code_of(i + 1));
    end
    check(!overrun_o, "R4", "no overrun at 4", int'(overrun_o), 0);
    write_byte(8'h55);
    check(overrun_o && level_o == 3'd4, "R4", "overrun and level", int'({overrun_o, level_o}), 12);
    div_i = 8'd1; wire_delay_i = 8'd0; frame_bits_i = 8'd0; exp_delay = 0;
    build(4, 0, 1'b0, 1);
    run_check(1'b0, "R4 fifth byte dropped");
    check(level_o == 0 && overrun_o, "R4", "drained, overrun sticky", int'({overrun_o, level_o}), 8);
    pulse_reinit();
    check(level_o == 0 && !overrun_o, "R11", "reinit clears", int'({overrun_o, level_o}), 0);

    // R2 bit order, R6 delay, R7 bit length, R12 debug clock
    tb_bytes[0] = 8'hB1;
    setup(1, 0, 1'b0, 3, 2);
    run_check(1'b0, "R2 R6 R7 R12 msb first");
    setup(1, 0, 1'b1, 4, 1);
    run_check(1'b1, "R2 swapped lsb first");

    // R5 underrun
    setup(0, 0, 1'b0, 2, 1);
    run_check(1'b0, "R5 empty go");
    check(underrun_o, "R5", "underrun set", int'(underrun_o), 1);
    setup(0, 12, 1'b0, 2, 0);
    run_check(1'b0, "R5 R9 padded frame");
    check(!underrun_o, "R5", "no underrun with frame size", int'(underrun_o), 0);

    // R7 divider change mid-bit
    tb_bytes[0] = 8'hA5;
    setup(1, 0, 1'b0, 4, 0);
    for (int k = 1; k < 8; k++) exp_dur[k] = 2;
    chg_j = 3; chg_div = 8'd2;
    run_check(1'b0, "R7 divider at boundary");
    clr_events();
    setup(1, 0, 1'b0, 0, 0);
    run_check(1'b0, "R7 divider zero as one");

    // R8 back-to-back and late writes; R6 go while busy ignored
    tb_bytes[0] = 8'h3C; tb_bytes[1] = 8'h81;
    setup(1, 0, 1'b0, 2, 0);
    build(2, 0, 1'b0, 2);
    ev_wr_j = 3; ev_wr_b = 8'h81; ev_go_j = 6;
    run_check(1'b0, "R8 R6 continuous frame, go ignored");
    clr_events();
    write_byte(8'h5A);
    repeat (10) begin
      @(negedge clk_i);
      if (oe_o || busy_o) break;
    end
    check(!oe_o && !busy_o && level_o == 3'd1, "R8", "late byte waits", int'({busy_o, oe_o, level_o}), 1);
    tb_bytes[0] = 8'h5A;
    build(1, 0, 1'b0, 2);
    run_check(1'b1, "R8 late byte on new go");

    // R9 truncation
    tb_bytes[0] = 8'hF0; tb_bytes[1] = 8'h0F;
    setup(2, 11, 1'b0, 1, 0);
    run_check(1'b0, "R9 cut at frame size");

    // R11 abort and hold
    setup(2, 0, 1'b0, 3, 0);
    @(negedge clk_i); go_i = 1'b1;
    @(negedge clk_i); go_i = 1'b0;
    repeat (6) @(negedge clk_i);
    check(oe_o, "R11", "shifting before abort", int'(oe_o), 1);
    reinit_i = 1'b1; go_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check({busy_o, oe_o, bclk_o, ser_o} == 4'b0011 && level_o == 0, "R11", "held idle",
          int'({busy_o, oe_o, bclk_o, ser_o, level_o}), 24);
    reinit_i = 1'b0; go_i = 1'b0;
    @(negedge clk_i);
    check(!busy_o, "R11", "go under reinit ignored", int'(busy_o), 0);

    // random frames
    for (int r = 0; r < 24; r++) begin
      nb  = 1 + int'($urandom % 4);
      frm = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 40);
      dv  = 1 + int'($urandom % 4);
      dly = int'($urandom % 5);
      sw  = 1'($urandom);
      gl  = 1'($urandom);
      for (int i = 0; i < 4; i++) tb_bytes[i] = 8'($urandom);
      setup(nb, frm, sw, dv, dly);
      run_check(gl, "R2 R6 R9 R10 random frame");
      ld  = (frm == 0) ? nb : (((frm + 7) / 8 < nb) ? (frm + 7) / 8 : nb);
      rem = nb - ld;
      check(level_o == 3'(rem), "R9", "bytes left after frame", int'(level_o), rem);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule